// File: doc/BRIEF.md
# Mode-Dependent Coded Watchdog Timer

This block is a watchdog timer. Its timeout is chosen by two things: a 6-bit period code, taken from a sparse set of ten codes, and the operating mode of the surrounding chip (Normal, Standby, Flash or Sleep). The same code gives a different timeout in each mode. In Standby and Sleep the longest code switches the watchdog off instead. Periods are given in milliseconds of a 512 kHz reference, so a timeout lasts `period_ms × 512` reference ticks. The `TICK_SHIFT` parameter divides that count by a power of two, which shortens the periods for simulation.

Firmware services the watchdog in one of two ways: it pulses `trigger`, or it writes a new valid code. Changing the mode also restarts the count. If the count reaches the selected period, the block raises `wdRst` for a fixed number of cycles and then counts again.

Entering Sleep while the off code is selected is a controlled shutdown. `wdRst` goes high first and `supplyEn` drops after it. Both stay that way until a `wake` pulse arrives. After `wake`, the supply returns first, the reset is released next, and counting restarts from zero.

Top module: `coded_watchdog`

## Requirements
- R1: After reset, `wdRst` is 0, `supplyEn` is 1, `codeErr` is 0, and the selected code is 001001 (the shortest one).
- R2: Ten codes are valid. From shortest to longest they are 001001, 001100, 010010, 010100, 011011, 100100, 101101, 110011, 110101, 110110. With `mode` = 00 (Normal) they select 14, 28, 56, 112, 140, 168, 196, 224, 252 and 280 ms. A period of P ms is `(P × 512) >> TICK_SHIFT` ticks, with a minimum of 1.
- R3: With `mode` = 01 (Standby), the first nine codes select 70, 140, 280, 560, 1120, 2240, 3584, 7168 and 14336 ms. Code 110110 disables the watchdog: `wdRst` never rises.
- R4: With `mode` = 10 (Flash), the ten codes select 70, 140, 280, 560, 1120, 2240, 3584, 7168, 14336 and 28672 ms.
- R5: With `mode` = 11 (Sleep), the first nine codes select 560, 1120, 2240, 3584, 7168, 10752, 14336, 21504 and 28672 ms. Code 110110 selects the off behaviour: no timeout while in Sleep.
- R6: A write (`codeWr` = 1) of any other code value is ignored, and the previous period stays in use. `codeErr` is 1 in the cycle after such a write, and only then.
- R7: The counter is cleared by any of three events: `trigger`, a write of a valid code, or a change of `mode`. The new period counts from that clearing clock edge, so `wdRst` rises exactly one period of ticks after it.
- R8: On a timeout, `wdRst` is 1 for exactly `RST_LEN` cycles. After it falls, a fresh period starts. `trigger` has no effect while `wdRst` is 1.
- R9: If `mode` changes to Sleep while code 110110 is selected, `wdRst` is 1 from the next cycle on. `supplyEn` falls one cycle after that, never before `wdRst`.
- R10: In that shut-down state, a `wake` pulse brings `supplyEn` back to 1 in the next cycle while `wdRst` stays 1. `wdRst` falls one cycle later, and counting restarts from zero after that.
- R11: The counter advances only in cycles with `tickIn` = 1. With `tickIn` held at 0, no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | One-cycle enable from the 512 kHz reference |
| mode | input | 2 | Operating mode: 00 Normal, 01 Standby, 10 Flash, 11 Sleep |
| codeWr | input | 1 | Period code write strobe |
| codeIn | input | 6 | Period code written with `codeWr` |
| trigger | input | 1 | Service pulse that restarts the count |
| wake | input | 1 | Wake event that leaves the Sleep shut-down state |
| wdRst | output | 1 | Reset output, high during a timeout pulse or shut-down |
| supplyEn | output | 1 | Supply enable, low only in the Sleep shut-down state |
| codeErr | output | 1 | One-cycle flag for a rejected code write |

## Verification
The bench builds the block with `TICK_SHIFT` = 9, with `tickIn` held at 1 for most of the run. At that setting each period in ticks equals its millisecond figure, so every entry of the four tables can be reached, including the 28672-tick Flash and Sleep periods. `RST_LEN` = 4 makes the pulse width and the restart after it easy to count. The mode-dependent off cases, the Sleep shut-down and wake ordering, and the rejection of invalid codes are all exercised.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  localparam int CODE_W    = 6;
  localparam int IDX_W     = 4;
  localparam int NUM_CODES = 10;
  localparam int MS_W      = 15;
  localparam int OSC_SHIFT = 9;   // 512 ticks per millisecond
  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_FLASH   = 2'b10,
    MODE_SLEEP   = 2'b11
  } wdMode_t;

  typedef enum logic [2:0] {
    ST_RUN, ST_PULSE, ST_SLEEP_RST, ST_SLEEP_OFF, ST_WAKE
  } wdState_t;

  // control -> datapath
  typedef struct packed {
    logic clrCnt;
    logic cntEn;
    logic loadCode;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic codeValid;
    logic atLimit;
    logic wdOff;
  } dpStatus_t;

  typedef logic [MS_W-1:0] msTable_t [NUM_CODES];

  localparam msTable_t NORM_MS  = '{14, 28, 56, 112, 140, 168, 196, 224, 252, 280};
  localparam msTable_t STBY_MS  = '{70, 140, 280, 560, 1120, 2240, 3584, 7168, 14336, 0};
  localparam msTable_t FLASH_MS = '{70, 140, 280, 560, 1120, 2240, 3584, 7168, 14336, 28672};
  localparam msTable_t SLEEP_MS = '{560, 1120, 2240, 3584, 7168, 10752, 14336, 21504, 28672, 0};

  function automatic logic [IDX_W-1:0] codeIndex(input logic [CODE_W-1:0] code);
    case (code)
      6'b001001: codeIndex = 4'd0;
      6'b001100: codeIndex = 4'd1;
      6'b010010: codeIndex = 4'd2;
      6'b010100: codeIndex = 4'd3;
      6'b011011: codeIndex = 4'd4;
      6'b100100: codeIndex = 4'd5;
      6'b101101: codeIndex = 4'd6;
      6'b110011: codeIndex = 4'd7;
      6'b110101: codeIndex = 4'd8;
      6'b110110: codeIndex = 4'd9;
      default:   codeIndex = IDX_NONE;
    endcase
  endfunction

  // Zero means the watchdog is off for this code/mode pair.
  function automatic logic [MS_W-1:0] periodMs(input logic [1:0] mode,
                                               input logic [IDX_W-1:0] idx);
    logic [MS_W-1:0] ms;
    ms = '0;
    if (idx < IDX_W'(NUM_CODES)) begin
      case (mode)
        MODE_NORMAL:  ms = NORM_MS[idx];
        MODE_STANDBY: ms = STBY_MS[idx];
        MODE_FLASH:   ms = FLASH_MS[idx];
        default:      ms = SLEEP_MS[idx];
      endcase
    end
    return ms;
  endfunction

endpackage

// File: rtl/cwd_datapath.sv
module cwd_datapath
  import cwd_pkg::*;
#(
  parameter int TICK_SHIFT = 0,
  parameter int CNT_W      = MS_W + OSC_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [CODE_W-1:0] codeIn,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status
);

  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] newIdx;
  logic [MS_W-1:0]  selMs;
  logic [CNT_W-1:0] scaled;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cntQ;

  assign newIdx = codeIndex(codeIn);
  assign selMs  = periodMs(mode, idxQ);
  assign scaled = CNT_W'({selMs, {OSC_SHIFT{1'b0}}} >> TICK_SHIFT);
  assign limit  = (scaled == '0) ? CNT_W'(1) : scaled;

  assign status.codeValid = (newIdx != IDX_NONE);
  assign status.wdOff     = (selMs == '0);
  assign status.atLimit   = (cntQ == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (strobe.loadCode) begin
      idxQ <= newIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.clrCnt) begin
      cntQ <= '0;
    end else if (strobe.cntEn) begin
      cntQ <= status.atLimit ? '0 : cntQ + CNT_W'(1);
    end
  end

endmodule

// File: rtl/cwd_ctrl.sv
module cwd_ctrl
  import cwd_pkg::*;
#(
  parameter int RST_LEN = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  mode,
  input  logic        codeWr,
  input  logic        trigger,
  input  logic        tickIn,
  input  logic        wake,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        wdRst,
  output logic        supplyEn,
  output logic        codeErr
);

  localparam int PCNT_W = (RST_LEN < 2) ? 1 : $clog2(RST_LEN);

  wdState_t    stateQ, stateD;
  logic [1:0]  prevModeQ;
  logic [PCNT_W-1:0] pulseQ, pulseD;
  logic        modeChg;
  logic        validWr;
  logic        sleepEntry;
  logic        running;
  logic        expire;

  assign modeChg    = (mode != prevModeQ);
  assign validWr    = codeWr & status.codeValid;
  assign running    = (stateQ == ST_RUN);
  assign sleepEntry = modeChg && (mode == MODE_SLEEP) && status.wdOff &&
                      ((stateQ == ST_RUN) || (stateQ == ST_PULSE));

  always_comb begin
    strobe.loadCode = validWr;
    strobe.clrCnt   = !running | trigger | validWr | modeChg | status.wdOff;
    strobe.cntEn    = running & tickIn & !strobe.clrCnt;
  end

  assign expire = strobe.cntEn & status.atLimit;

  always_comb begin
    stateD = stateQ;
    pulseD = pulseQ;
    case (stateQ)
      ST_RUN: begin
        if (sleepEntry) begin
          stateD = ST_SLEEP_RST;
        end else if (expire) begin
          stateD = ST_PULSE;
          pulseD = PCNT_W'(RST_LEN - 1);
        end
      end
      ST_PULSE: begin
        if (sleepEntry) begin
          stateD = ST_SLEEP_RST;
        end else if (pulseQ == '0) begin
          stateD = ST_RUN;
        end else begin
          pulseD = pulseQ - PCNT_W'(1);
        end
      end
      ST_SLEEP_RST: stateD = ST_SLEEP_OFF;
      ST_SLEEP_OFF: if (wake) stateD = ST_WAKE;
      ST_WAKE:      stateD = ST_RUN;
      default:      stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_RUN;
      pulseQ    <= '0;
      prevModeQ <= MODE_NORMAL;
      codeErr   <= 1'b0;
    end else begin
      stateQ    <= stateD;
      pulseQ    <= pulseD;
      prevModeQ <= mode;
      codeErr   <= codeWr & !status.codeValid;
    end
  end

  assign wdRst    = (stateQ != ST_RUN);
  assign supplyEn = (stateQ != ST_SLEEP_OFF);

endmodule

// File: rtl/coded_watchdog.sv
module coded_watchdog
  import cwd_pkg::*;
#(
  parameter int TICK_SHIFT = 0,
  parameter int RST_LEN    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic [1:0] mode,
  input  logic       codeWr,
  input  logic [5:0] codeIn,
  input  logic       trigger,
  input  logic       wake,
  output logic       wdRst,
  output logic       supplyEn,
  output logic       codeErr
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  cwd_datapath #(.TICK_SHIFT(TICK_SHIFT)) uDatapath (
    .clk    (clk),
    .rstN   (rstN),
    .mode   (mode),
    .codeIn (codeIn),
    .strobe (strobe),
    .status (status)
  );

  cwd_ctrl #(.RST_LEN(RST_LEN)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .mode     (mode),
    .codeWr   (codeWr),
    .trigger  (trigger),
    .tickIn   (tickIn),
    .wake     (wake),
    .status   (status),
    .strobe   (strobe),
    .wdRst    (wdRst),
    .supplyEn (supplyEn),
    .codeErr  (codeErr)
  );

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
  parameter int RST_LEN = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       tickIn,
  input logic [1:0] mode,
  input logic       codeWr,
  input logic       trigger,
  input logic       wake,
  input logic       wdRst,
  input logic       supplyEn,
  input logic       codeErr
);

  logic [31:0] hiLenQ;
  logic        sleepSeenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiLenQ     <= '0;
      sleepSeenQ <= 1'b0;
    end else if (wdRst) begin
      hiLenQ <= hiLenQ + 32'd1;
      if (!supplyEn) sleepSeenQ <= 1'b1;
    end else begin
      hiLenQ     <= '0;
      sleepSeenQ <= 1'b0;
    end
  end

  a_r9_supply_after_rst: assert property (@(posedge clk) disable iff (!rstN)
    $fell(supplyEn) |-> $past(wdRst));

  a_r10_supply_before_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdRst) |-> (supplyEn && $past(supplyEn)));

  a_r10_wake_restores_supply: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyEn && wake) |=> (supplyEn && wdRst));

  a_r6_err_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |-> $past(codeWr));

  a_r7_trigger_defers_timeout: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && !wdRst && mode != 2'b11) |=> !wdRst);

  a_r11_no_tick_no_timeout: assert property (@(posedge clk) disable iff (!rstN)
    (!tickIn && !wdRst && mode != 2'b11) |=> !wdRst);

  a_r8_pulse_length: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(wdRst) && !sleepSeenQ) |-> (hiLenQ == RST_LEN));

endmodule

bind coded_watchdog cwd_checker #(.RST_LEN(RST_LEN)) uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .tickIn   (tickIn),
  .mode     (mode),
  .codeWr   (codeWr),
  .trigger  (trigger),
  .wake     (wake),
  .wdRst    (wdRst),
  .supplyEn (supplyEn),
  .codeErr  (codeErr)
);

// File: tb/sim_coded_watchdog.sv
`timescale 1ns/1ps
module sim_coded_watchdog;

  localparam int RST_LEN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b1;
  logic [1:0] mode = 2'b00;
  logic codeWr = 1'b0;
  logic [5:0] codeIn = 6'b0;
  logic trigger = 1'b0;
  logic wake = 1'b0;
  logic wdRst, supplyEn, codeErr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  coded_watchdog #(.TICK_SHIFT(9), .RST_LEN(RST_LEN)) u0 (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .mode(mode), .codeWr(codeWr),
    .codeIn(codeIn), .trigger(trigger), .wake(wake),
    .wdRst(wdRst), .supplyEn(supplyEn), .codeErr(codeErr)
  );

  function automatic logic [5:0] codeOf(int idx);
    case (idx)
      0: return 6'b001001; 1: return 6'b001100; 2: return 6'b010010;
      3: return 6'b010100; 4: return 6'b011011; 5: return 6'b100100;
      6: return 6'b101101; 7: return 6'b110011; 8: return 6'b110101;
      default: return 6'b110110;
    endcase
  endfunction

  // Expected period in ticks at TICK_SHIFT = 9 (equals the ms figure); 0 = off.
  function automatic int expTicks(int m, int idx);
    int nrm[10] = '{14, 28, 56, 112, 140, 168, 196, 224, 252, 280};
    int stb[10] = '{70, 140, 280, 560, 1120, 2240, 3584, 7168, 14336, 0};
    int fls[10] = '{70, 140, 280, 560, 1120, 2240, 3584, 7168, 14336, 28672};
    int slp[10] = '{560, 1120, 2240, 3584, 7168, 10752, 14336, 21504, 28672, 0};
    case (m)
      0: return nrm[idx];
      1: return stb[idx];
      2: return fls[idx];
      default: return slp[idx];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts just after a negedge. Counts posedges until wdRst is seen high;
  // the first posedge is the one that samples any strobe set by the caller.
  task automatic waitRst(input int cap, output int n);
    n = 0;
    while (n < cap) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      trigger = 1'b0;
      codeWr  = 1'b0;
      if (wdRst) break;
    end
  endtask

  task automatic waitLow();
    while (wdRst) @(negedge clk);
  endtask

  task automatic writeCode(input logic [5:0] c, output bit err);
    codeIn = c;
    codeWr = 1'b1;
    @(negedge clk);
    codeWr = 1'b0;
    err = codeErr;
  endtask

  task automatic setMode(input logic [1:0] m);
    mode = m;
    @(negedge clk);
  endtask

  task automatic measure(input int exp, input string req);
    int n;
    waitLow();
    trigger = 1'b1;
    waitRst(exp + 20, n);
    check(wdRst && (n - 1 == exp), req, n - 1, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit err;
    int n;
    int h;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!wdRst, "R1 wdRst", int'(wdRst), 0);
    check(supplyEn, "R1 supplyEn", int'(supplyEn), 1);
    check(!codeErr, "R1 codeErr", int'(codeErr), 0);
    measure(14, "R1 default code period");

    // R2 all Normal codes
    for (int i = 0; i < 10; i++) begin
      waitLow();
      writeCode(codeOf(i), err);
      check(!err, "R2 valid write no error", int'(err), 0);
      measure(expTicks(0, i), "R2 Normal period");
    end

    // R4 Flash
    setMode(2'b10);
    measure(28672, "R4 Flash longest");
    waitLow();
    writeCode(codeOf(0), err);
    measure(70, "R4 Flash shortest");

    // R3 Standby
    waitLow();
    setMode(2'b01);
    writeCode(codeOf(3), err);
    measure(560, "R3 Standby code 3");
    waitLow();
    writeCode(codeOf(9), err);
    waitRst(15000, n);
    check(!wdRst, "R3 Standby off code", int'(wdRst), 0);

    // R5 Sleep (non-off codes)
    writeCode(codeOf(0), err);
    setMode(2'b11);
    measure(560, "R5 Sleep shortest");
    waitLow();
    writeCode(codeOf(8), err);
    measure(28672, "R5 Sleep code 8");
    waitLow();
    setMode(2'b00);

    // R6 invalid codes
    writeCode(codeOf(1), err);
    writeCode(6'b000000, err);
    check(err, "R6 codeErr after invalid write", int'(err), 1);
    @(negedge clk);
    check(!codeErr, "R6 codeErr one cycle", int'(codeErr), 0);
    writeCode(6'b111111, err);
    check(err, "R6 codeErr second invalid", int'(err), 1);
    measure(28, "R6 period kept after invalid write");

    // R7 clear by valid write and by mode change
    waitLow();
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    repeat (10) @(negedge clk);
    codeIn = codeOf(2);
    codeWr = 1'b1;
    waitRst(100, n);
    check(n - 1 == 56, "R7 count from code write", n - 1, 56);
    waitLow();
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    repeat (10) @(negedge clk);
    mode = 2'b10;
    waitRst(400, n);
    check(n - 1 == 280, "R7 count from mode change", n - 1, 280);

    // R8 pulse width and restart
    waitLow();
    setMode(2'b00);
    writeCode(codeOf(0), err);
    measure(14, "R8 setup period");
    h = 1;
    trigger = 1'b1;               // ignored during the pulse
    @(negedge clk);
    trigger = 1'b0;
    h++;
    while (wdRst) begin
      @(negedge clk);
      if (wdRst) h++;
    end
    check(h == RST_LEN, "R8 pulse length", h, RST_LEN);
    waitRst(50, n);
    check(n == 14, "R8 restart after pulse", n, 14);

    // R11 tick gating
    waitLow();
    tickIn = 1'b0;
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    waitRst(200, n);
    check(!wdRst, "R11 no timeout without ticks", int'(wdRst), 0);
    tickIn = 1'b1;
    waitRst(50, n);
    check(n == 14, "R11 ticks resume count", n, 14);

    // R9 / R10 Sleep entry with off code
    waitLow();
    writeCode(codeOf(9), err);
    mode = 2'b11;
    @(negedge clk);
    check(wdRst && supplyEn, "R9 reset first, supply still on",
          {wdRst, supplyEn}, 2'b11);
    @(negedge clk);
    check(wdRst && !supplyEn, "R9 supply off after reset",
          {wdRst, supplyEn}, 2'b10);
    repeat (50) @(negedge clk);
    check(wdRst && !supplyEn, "R9 shut-down held", {wdRst, supplyEn}, 2'b10);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    check(wdRst && supplyEn, "R10 supply back before release",
          {wdRst, supplyEn}, 2'b11);
    @(negedge clk);
    check(!wdRst && supplyEn, "R10 reset released", {wdRst, supplyEn}, 2'b01);
    waitRst(200, n);
    check(!wdRst, "R5 Sleep off code no timeout", int'(wdRst), 0);
    mode = 2'b00;
    waitRst(400, n);
    check(n - 1 == 280, "R10 counting resumes", n - 1, 280);

    // Random mix over Normal/Standby/Flash
    for (int k = 0; k < 10; k++) begin
      int m;
      int idx;
      m   = int'($urandom % 3);
      idx = int'($urandom % 7);
      waitLow();
      writeCode(codeOf(idx), err);
      setMode(m[1:0]);
      case (m)
        0: measure(expTicks(m, idx), "R2 random Normal");
        1: measure(expTicks(m, idx), "R3 random Standby");
        default: measure(expTicks(m, idx), "R4 random Flash");
      endcase
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule